// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store of `DEPTH` words held in flip-flops. It is driven by one-cycle push and pop requests. A single stack pointer addresses the current top word. The block keeps no occupancy counter. Instead, both the full condition and the empty condition are detected when the pointer lands on zero after an operation:

- The first pushed word goes to location 1.
- Later words climb upward.
- The word that completes the stack goes to location 0, once the pointer wraps.

A push advances the pointer and writes the input word at the new top. A pop copies the top word into a registered output and then steps the pointer back.

Three kinds of request are illegal: a push while full, a pop while empty, and a push and a pop in the same cycle. The block ignores them. The pointer, the storage, the flags and the output word all keep their values. A one-cycle error pulse reports the refused request.

Top module: `regstack_top`

## Requirements
- R1: After a synchronous reset, `top_ptr` is 0, `empty` is 1, `full` is 0, `err` is 0 and `rd_data` is 0.
- R2: A legal push (push_req=1, pop_req=0, full=0) raises `top_ptr` by one, modulo DEPTH, at the next clock edge. A legal pop (pop_req=1, push_req=0, empty=0) lowers it by one at the next clock edge.
- R3: After a legal push, `empty` is 0. `full` becomes 1 exactly when the new pointer is 0, which is the DEPTH-th push from empty.
- R4: After a legal pop, `full` is 0. `empty` becomes 1 exactly when the new pointer is 0.
- R5: A legal pop places the top word on `rd_data` one clock after the request. `rd_data` holds that value until the next legal pop. Words come out in the reverse of the order in which they were pushed.
- R6: A push while `full`=1 pulses `err` and leaves the pointer, the flags and the stored words unchanged.
- R7: A pop while `empty`=1 pulses `err` and leaves the pointer, the flags and `rd_data` unchanged.
- R8: A push and a pop requested in the same cycle are treated as an error. `err` pulses, and nothing else changes.
- R9: `err` is high for exactly the one cycle after an illegal request and is 0 after legal or idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to push `wr_data` |
| pop_req | input | 1 | Request to pop the top word |
| wr_data | input | DATA_W | Word to push |
| rd_data | output | DATA_W | Last popped word (registered) |
| top_ptr | output | $clog2(DEPTH) | Current stack pointer |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no word |
| err | output | 1 | One-cycle pulse after an illegal request |

## Verification
The properties assume that `push_req` and `pop_req` are free of X after reset and are sampled only at the rising edge. They also assume that DEPTH is a power of two, so that the pointer's natural wrap is the stack's wrap. The stimulus changes inputs only on the falling edge and holds each request for a single cycle. It also deliberately produces each illegal combination, including a simultaneous push and pop while the stack is full. That way, the refusal properties are reached with the flags in both extreme states.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_BAD
    } stk_op_e;

    typedef struct packed {
        logic full;
        logic empty;
    } stk_flags_t;

    localparam stk_flags_t FLAGS_AT_RESET = '{full: 1'b0, empty: 1'b1};

    function automatic stk_op_e decode_op(
        input logic push,
        input logic pop,
        input logic is_full,
        input logic is_empty
    );
        if (push && pop) return OP_BAD;
        if (push)        return is_full  ? OP_BAD : OP_PUSH;
        if (pop)         return is_empty ? OP_BAD : OP_POP;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
    import regstack_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] sp,
    output logic             full,
    output logic             empty,
    output logic             err,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr
);

    stk_op_e          op;
    stk_flags_t       flags_q, flags_d;
    logic [PTR_W-1:0] sp_q, sp_d, sp_inc, sp_dec;
    logic             err_q, err_d;

    assign op     = decode_op(push_req, pop_req, flags_q.full, flags_q.empty);
    assign sp_inc = sp_q + 1'b1;
    assign sp_dec = sp_q - 1'b1;

    always_comb begin
        sp_d    = sp_q;
        flags_d = flags_q;
        err_d   = 1'b0;
        unique case (op)
            OP_PUSH: begin
                sp_d          = sp_inc;
                flags_d.full  = (sp_inc == '0);
                flags_d.empty = 1'b0;
            end
            OP_POP: begin
                sp_d          = sp_dec;
                flags_d.empty = (sp_dec == '0);
                flags_d.full  = 1'b0;
            end
            OP_BAD:  err_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            flags_q <= FLAGS_AT_RESET;
            err_q   <= 1'b0;
        end else begin
            sp_q    <= sp_d;
            flags_q <= flags_d;
            err_q   <= err_d;
        end
    end

    // The write lands at the incremented location on the same edge as the pointer update.
    assign wr_en   = (op == OP_PUSH);
    assign wr_addr = sp_inc;
    assign rd_en   = (op == OP_POP);
    assign rd_addr = sp_q;

    assign sp    = sp_q;
    assign full  = flags_q.full;
    assign empty = flags_q.empty;
    assign err   = err_q;

endmodule

// File: rtl/regstack_store.sv
module regstack_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] cells;
    logic [DATA_W-1:0]            rd_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g))) cell_q <= wr_data;
        end
        assign cells[g] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= cells[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/regstack_top.sv
module regstack_top #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              full,
    output logic              empty,
    output logic              err
);

    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;

    regstack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .sp       (top_ptr),
        .full     (full),
        .empty    (empty),
        .err      (err),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr)
    );

    regstack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/regstack_chk.sv
module regstack_chk #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              push_req,
    input logic              pop_req,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  top_ptr,
    input logic              full,
    input logic              empty,
    input logic              err
);

    // R3
    full_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (top_ptr == '0));

    // R4
    empty_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (top_ptr == '0));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !full) |=> (top_ptr == PTR_W'($past(top_ptr) + 1'b1)) && !empty);

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !empty) |=> (top_ptr == PTR_W'($past(top_ptr) - 1'b1)) && !full);

    // R6
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && full) |=> err && full && $stable(top_ptr));

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && empty) |=> err && empty && $stable(top_ptr) && $stable(rd_data));

    // R8
    both_req_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> err && $stable(top_ptr) && $stable(full) && $stable(empty) && $stable(rd_data));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_req && !pop_req) |=> !err);

endmodule

bind regstack_top regstack_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .rd_data  (rd_data),
    .top_ptr  (top_ptr),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/regstack_top_tb.sv
`timescale 1ns/1ps
module regstack_top_tb;

    localparam int DW  = 8;
    localparam int DEP = 64;
    localparam int PW  = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [PW-1:0] top_ptr;
    logic          full, empty, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    regstack_top #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .wr_data(wr_data), .rd_data(rd_data), .top_ptr(top_ptr),
        .full(full), .empty(empty), .err(err)
    );

    typedef struct packed {
        logic          push;
        logic          pop;
        logic [DW-1:0] din;
        logic [PW-1:0] ptr;
        logic          fl;
        logic          em;
        logic          er;
        logic [DW-1:0] rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hA1, 6'd1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hB2, 6'd2, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'hB2},
        '{1'b1, 1'b1, 8'h77, 6'd1, 1'b0, 1'b0, 1'b1, 8'hB2},
        '{1'b0, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'hB2},
        '{1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 8'hA1},
        '{1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b1, 8'hA1},
        '{1'b1, 1'b0, 8'h3C, 6'd1, 1'b0, 1'b0, 1'b0, 8'hA1},
        '{1'b1, 1'b0, 8'h4D, 6'd2, 1'b0, 1'b0, 1'b0, 8'hA1},
        '{1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'h4D},
        '{1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 8'h3C}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive on the falling edge; results are read at the following falling edge.
    task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
        push_req = p;
        pop_req  = q;
        wr_data  = d;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ptr", int'(top_ptr), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 err", int'(err), 0);
        check("R1 rd_data", int'(rd_data), 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].push, VECS[i].pop, VECS[i].din);
            check("R2 vector ptr", int'(top_ptr), int'(VECS[i].ptr));
            check("R3 vector full", int'(full), int'(VECS[i].fl));
            check("R4 vector empty", int'(empty), int'(VECS[i].em));
            check("R9 vector err", int'(err), int'(VECS[i].er));
            check("R5 vector rd_data", int'(rd_data), int'(VECS[i].rd));
        end

        // Fill to capacity; the last push wraps the pointer to zero.
        for (int k = 0; k < DEP; k++) begin
            step(1'b1, 1'b0, DW'(k + 1));
            check("R2 fill ptr", int'(top_ptr), (k + 1) % DEP);
            check("R3 fill full", int'(full), (k == DEP - 1) ? 1 : 0);
            check("R3 fill empty", int'(empty), 0);
        end

        step(1'b1, 1'b0, 8'hEE);
        check("R6 err", int'(err), 1);
        check("R6 full", int'(full), 1);
        check("R6 ptr", int'(top_ptr), 0);
        step(1'b0, 1'b0, 8'h00);
        check("R9 err drop", int'(err), 0);

        step(1'b1, 1'b1, 8'hDD);
        check("R8 err", int'(err), 1);
        check("R8 ptr", int'(top_ptr), 0);
        check("R8 full", int'(full), 1);
        check("R8 rd_data", int'(rd_data), 8'h3C);

        // Drain: words return in reverse order; the refused pushes stored nothing.
        for (int k = 0; k < DEP; k++) begin
            step(1'b0, 1'b1, 8'h00);
            check("R5 drain rd_data", int'(rd_data), DEP - k);
            check("R4 drain full", int'(full), 0);
            check("R4 drain empty", int'(empty), (k == DEP - 1) ? 1 : 0);
            check("R9 drain err", int'(err), 0);
        end

        step(1'b0, 1'b1, 8'h00);
        check("R7 err", int'(err), 1);
        check("R7 empty", int'(empty), 1);
        check("R7 ptr", int'(top_ptr), 0);
        check("R7 rd_data", int'(rd_data), 1);
        step(1'b0, 1'b0, 8'h00);
        check("R9 err idle", int'(err), 0);
        check("R5 rd_data hold", int'(rd_data), 1);

        // Reset in the middle of operation.
        step(1'b1, 1'b0, 8'h55);
        check("R2 ptr before reset", int'(top_ptr), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ptr again", int'(top_ptr), 0);
        check("R1 empty again", int'(empty), 1);
        check("R1 rd_data again", int'(rd_data), 0);
        step(1'b0, 1'b1, 8'h00);
        check("R7 pop after reset", int'(err), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule